// File: doc/BRIEF.md
# Timebase Interval Timer

This block is a free-running prescaled up-counter that serves as the common time reference for a group of neighbouring timers. The counter advances on every second cycle of the oscillator clock. Its full value is exposed as a tap bus, so that a PWM timer, a watchdog and an oscillation-stabilisation-wait selector can pick the bits they need. A small control register selects one of four carry points of the counter as the interval event. The event latches a sticky flag, and the flag together with an enable bit raises an interrupt request.

The counter restarts from zero on several conditions: synchronous reset, a software clear command in the control register, a pulse that marks entry to either stop mode, and a pulse for each of the three machine-clock source changes. Each of these conditions also resets the divide-by-two phase. After any clear, the interval timing is therefore exact.

Top module: `timebase_timer`

## Requirements
- R1: While and after `rst` is high, `tap_o` is 0, `irq_o` is 0, and `reg_rdata` reads 0x08: select 00, enable 0, clear bit 1, flag 0.
- R2: The counter advances by exactly one on every second clock, and never on two consecutive clocks. If a clear is applied at clock edge 0, `tap_o` equals floor(m/2) after edge m.
- R3: A register write with bit 3 at 0 clears the counter and the prescaler phase. A write with bit 3 at 1 leaves the count unchanged. Bit 3 always reads as 1.
- R4: A one-cycle pulse on `stop_main_i` or `stop_pll_i` clears the counter on the next edge.
- R5: A one-cycle pulse on `sw_main_to_pll_i`, `sw_sub_to_pll_i` or `sw_sub_to_main_i` clears the counter on the next edge.
- R6: The select field in register bits [1:0] takes a value s from 0 to 3. It chooses the carry out of counter bit TAP_BASE+2s as the interval event. After a clear at edge 0, the flag in bit 4 rises at edge 2^(TAP_BASE+2s+2) and not before. With the default parameters this is 2^13, 2^15, 2^17 or 2^19 clocks.
- R7: The flag is sticky. A register write with bit 4 at 0 clears it, and a write with bit 4 at 1 leaves it unchanged.
- R8: If an interval event and a flag-clearing write fall on the same edge, the flag ends at 1.
- R9: `irq_o` is 1 exactly when the flag (bit 4) and the interrupt enable (bit 2) are both 1.
- R10: A clear on the edge where a carry would occur suppresses that event, and timing restarts from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data: [1:0] select, [2] enable, [3] clear command (active 0), [4] flag clear (active 0) |
| stop_main_i | input | 1 | Pulse on entry to main stop mode |
| stop_pll_i | input | 1 | Pulse on entry to PLL stop mode |
| sw_main_to_pll_i | input | 1 | Pulse on machine-clock switch from main to PLL |
| sw_sub_to_pll_i | input | 1 | Pulse on machine-clock switch from sub to PLL |
| sw_sub_to_main_i | input | 1 | Pulse on machine-clock switch from sub to main |
| reg_rdata | output | 8 | Register read value |
| irq_o | output | 1 | Interval interrupt request |
| tap_o | output | CNT_W | Counter value for neighbouring timers |

## Verification
The bench times the flag edge for every select value to the exact clock after a clear. A design that kept the prescaler phase across a clear, or tapped the wrong bit, would set the flag one clock or a factor of four off. It places a flag-clearing write on the very edge of an interval event; a design that gave the clear priority would lose that event. It fires a clear on the edge of a would-be carry, and checks that no flag appears and that timing restarts there. It also checks that writes with the clear or flag bit at 1 leave the count and the flag alone, which catches inverted write decoding.

// File: rtl/timebase_timer_pkg.sv
package timebase_timer_pkg;
  localparam int REG_W    = 8;
  localparam int SEL_W    = 2;
  localparam int BIT_IE   = 2;
  localparam int BIT_INIT = 3;
  localparam int BIT_FLAG = 4;
  localparam int N_EVT    = 5;

  typedef struct packed {
    logic             flag;
    logic             ie;
    logic [SEL_W-1:0] sel;
  } ctrl_t;
endpackage

// File: rtl/timebase_prescale.sv
module timebase_prescale #(
  parameter int PRE_W = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick_o
);
  logic [PRE_W-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (rst || clr) ph_q <= '0;
    else            ph_q <= ph_q + 1'b1;
  end

  // advance enable once every 2^PRE_W clocks
  assign tick_o = &ph_q;
endmodule

// File: rtl/timebase_clear.sv
module timebase_clear #(
  parameter int N_EVT = 5
) (
  input  logic             sw_clr_i,
  input  logic [N_EVT-1:0] evt_i,
  output logic             clr_o
);
  logic [N_EVT:0] chain;

  assign chain[0] = sw_clr_i;
  for (genvar i = 0; i < N_EVT; i++) begin : g_or
    assign chain[i+1] = chain[i] | evt_i[i];
  end
  assign clr_o = chain[N_EVT];
endmodule

// File: rtl/timebase_counter.sv
module timebase_counter #(
  parameter int CNT_W    = 18,
  parameter int N_TAP    = 4,
  parameter int TAP_BASE = 11,
  parameter int TAP_STEP = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_o,
  output logic [N_TAP-1:0] carry_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (tick)  cnt_q <= cnt_q + 1'b1;
  end

  // carry out of bit K: all low bits set while the count advances
  for (genvar i = 0; i < N_TAP; i++) begin : g_tap
    localparam int K = TAP_BASE + i * TAP_STEP;
    assign carry_o[i] = tick & ~clr & (&cnt_q[K:0]);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/timebase_ctrl.sv
module timebase_ctrl
  import timebase_timer_pkg::*;
#(
  parameter int N_TAP = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [N_TAP-1:0] carry_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             irq_o,
  output logic             sw_clr_o
);
  ctrl_t ctrl_q;
  logic  evt;
  logic  unused_wbits;

  assign evt          = carry_i[ctrl_q.sel];
  assign unused_wbits = ^wdata_i[REG_W-1:BIT_FLAG+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else begin
      if (we_i) begin
        ctrl_q.sel <= wdata_i[SEL_W-1:0];
        ctrl_q.ie  <= wdata_i[BIT_IE];
      end
      // a set event outranks a software clear on the same edge
      if (evt)                             ctrl_q.flag <= 1'b1;
      else if (we_i && !wdata_i[BIT_FLAG]) ctrl_q.flag <= 1'b0;
    end
  end

  always_comb begin
    rdata_o              = '0;
    rdata_o[SEL_W-1:0]   = ctrl_q.sel;
    rdata_o[BIT_IE]      = ctrl_q.ie;
    rdata_o[BIT_INIT]    = 1'b1;
    rdata_o[BIT_FLAG]    = ctrl_q.flag;
  end

  assign irq_o    = ctrl_q.flag & ctrl_q.ie;
  assign sw_clr_o = we_i & ~wdata_i[BIT_INIT];
endmodule

// File: rtl/timebase_timer.sv
module timebase_timer
  import timebase_timer_pkg::*;
#(
  parameter int CNT_W    = 18,
  parameter int TAP_BASE = 11,
  parameter int TAP_STEP = 2,
  parameter int PRE_W    = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             stop_main_i,
  input  logic             stop_pll_i,
  input  logic             sw_main_to_pll_i,
  input  logic             sw_sub_to_pll_i,
  input  logic             sw_sub_to_main_i,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq_o,
  output logic [CNT_W-1:0] tap_o
);
  localparam int N_TAP = 1 << SEL_W;

  logic             sw_clr, clr, tick;
  logic [N_EVT-1:0] evt;
  logic [N_TAP-1:0] carry;

  assign evt = {sw_sub_to_main_i, sw_sub_to_pll_i, sw_main_to_pll_i,
                stop_pll_i, stop_main_i};

  timebase_clear #(.N_EVT(N_EVT)) u_clear (
    .sw_clr_i(sw_clr), .evt_i(evt), .clr_o(clr)
  );

  timebase_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .clr(clr), .tick_o(tick)
  );

  timebase_counter #(
    .CNT_W(CNT_W), .N_TAP(N_TAP), .TAP_BASE(TAP_BASE), .TAP_STEP(TAP_STEP)
  ) u_cnt (
    .clk(clk), .rst(rst), .clr(clr), .tick(tick),
    .cnt_o(tap_o), .carry_o(carry)
  );

  timebase_ctrl #(.N_TAP(N_TAP)) u_ctrl (
    .clk(clk), .rst(rst), .we_i(reg_we), .wdata_i(reg_wdata),
    .carry_i(carry), .rdata_o(reg_rdata), .irq_o(irq_o), .sw_clr_o(sw_clr)
  );
endmodule

// File: rtl/timebase_timer_checker.sv
module timebase_timer_checker #(
  parameter int CNT_W = 18
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_we,
  input logic             wr_init,
  input logic             wr_flag,
  input logic             stop_main_i,
  input logic             stop_pll_i,
  input logic             sw_main_to_pll_i,
  input logic             sw_sub_to_pll_i,
  input logic             sw_sub_to_main_i,
  input logic [7:0]       reg_rdata,
  input logic             irq_o,
  input logic [CNT_W-1:0] tap_o
);
  logic any_clr;
  assign any_clr = stop_main_i | stop_pll_i | sw_main_to_pll_i |
                   sw_sub_to_pll_i | sw_sub_to_main_i | (reg_we & ~wr_init);

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (tap_o == '0 && reg_rdata == 8'h08 && !irq_o));

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (tap_o != $past(tap_o)) |-> (tap_o == $past(tap_o) + 1'b1 || tap_o == '0));

  p_no_burst_r2: assert property (@(posedge clk) disable iff (rst)
    (tap_o != $past(tap_o) && tap_o != '0) |=> (tap_o == $past(tap_o) || tap_o == '0));

  p_init_reads_one_r3: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[3]);

  p_event_clear_r4: assert property (@(posedge clk) disable iff (rst)
    any_clr |=> (tap_o == '0));

  p_flag_fall_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(reg_rdata[4]) |-> $past(reg_we && !wr_flag));

  p_irq_r9: assert property (@(posedge clk) disable iff (rst)
    irq_o == (reg_rdata[4] & reg_rdata[2]));
endmodule

bind timebase_timer timebase_timer_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we),
  .wr_init(reg_wdata[3]), .wr_flag(reg_wdata[4]),
  .stop_main_i(stop_main_i), .stop_pll_i(stop_pll_i),
  .sw_main_to_pll_i(sw_main_to_pll_i), .sw_sub_to_pll_i(sw_sub_to_pll_i),
  .sw_sub_to_main_i(sw_sub_to_main_i),
  .reg_rdata(reg_rdata), .irq_o(irq_o), .tap_o(tap_o)
);

// File: tb/timebase_timer_bench.sv
module timebase_timer_bench;
  localparam int CW = 8;
  localparam int TB = 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          we  = 1'b0;
  logic [7:0]    wd  = '0;
  logic [4:0]    ev  = '0;
  logic [7:0]    rd;
  logic          irq;
  logic [CW-1:0] tap;
  int errs   = 0;
  int checks = 0;

  always #2 clk = ~clk;

  timebase_timer #(.CNT_W(CW), .TAP_BASE(TB), .TAP_STEP(2), .PRE_W(1)) u_timebase_timer (
    .clk(clk), .rst(rst), .reg_we(we), .reg_wdata(wd),
    .stop_main_i(ev[0]), .stop_pll_i(ev[1]), .sw_main_to_pll_i(ev[2]),
    .sw_sub_to_pll_i(ev[3]), .sw_sub_to_main_i(ev[4]),
    .reg_rdata(rd), .irq_o(irq), .tap_o(tap)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    we = 1'b1; wd = d;
    @(negedge clk);
    we = 1'b0; wd = '0;
  endtask

  task automatic pulse(input int idx);
    ev[idx] = 1'b1;
    @(negedge clk);
    ev = '0;
  endtask

  function automatic logic [7:0] cfg(input logic [1:0] sel, input logic ie,
                                     input logic flag_keep, input logic init_keep);
    return {3'b000, flag_keep, init_keep, ie, sel};
  endfunction

  // clear edge is the write edge; returns at the negedge just after it
  task automatic clean(input logic [1:0] sel, input logic ie);
    pulse(0);
    wr(cfg(sel, ie, 1'b0, 1'b0));
  endtask

  task automatic t_reset();
    tick(3);
    chk("R1 rdata in reset", rd, 8'h08);
    chk("R1 tap in reset", tap, 0);
    rst = 1'b0;
    tick(1);
    chk("R1 irq after reset", irq, 0);
    chk("R1 rdata after reset", rd, 8'h08);
  endtask

  task automatic t_count();
    clean(2'd0, 1'b0);
    chk("R2 tap at clear", tap, 0);
    for (int m = 1; m <= 6; m++) begin
      tick(1);
      chk("R2 tap progression", tap, m / 2);
    end
    tick(14);
    chk("R2 tap after 20 edges", tap, 10);
  endtask

  task automatic t_init();
    clean(2'd0, 1'b0);
    chk("R3 clear bit reads 1", rd[3], 1);
    tick(5);
    wr(cfg(2'd0, 1'b0, 1'b1, 1'b1));
    chk("R3 write 1 keeps count", tap, 3);
    wr(cfg(2'd0, 1'b0, 1'b1, 1'b0));
    chk("R3 write 0 clears count", tap, 0);
    tick(3);
    chk("R3 prescaler restarted", tap, 1);
  endtask

  task automatic t_events();
    for (int i = 0; i < 5; i++) begin
      clean(2'd0, 1'b0);
      tick(9);
      chk(i < 2 ? "R4 count before stop" : "R5 count before switch", tap, 4);
      pulse(i);
      chk(i < 2 ? "R4 stop clears" : "R5 switch clears", tap, 0);
      tick(3);
      chk(i < 2 ? "R4 restart" : "R5 restart", tap, 1);
    end
  endtask

  task automatic t_sel();
    for (int s = 0; s < 4; s++) begin
      int n;
      n = 8 << (2 * s);
      clean(s[1:0], 1'b0);
      chk("R6 select readback", rd[1:0], s);
      tick(n - 1);
      chk("R6 flag not yet", rd[4], 0);
      tick(1);
      chk("R6 flag at period", rd[4], 1);
    end
  endtask

  task automatic t_flag();
    clean(2'd0, 1'b0);
    tick(7);
    wr(cfg(2'd0, 1'b0, 1'b0, 1'b1));
    chk("R8 set wins over clear", rd[4], 1);
    tick(20);
    chk("R7 flag sticky", rd[4], 1);
    wr(cfg(2'd0, 1'b0, 1'b1, 1'b1));
    chk("R7 write 1 keeps flag", rd[4], 1);
    wr(cfg(2'd0, 1'b0, 1'b0, 1'b1));
    chk("R7 write 0 clears flag", rd[4], 0);
    wr(cfg(2'd0, 1'b0, 1'b1, 1'b1));
    chk("R7 write 1 keeps flag low", rd[4], 0);
  endtask

  task automatic t_clear_at_carry();
    clean(2'd0, 1'b0);
    tick(7);
    pulse(1);
    chk("R10 no flag on cleared carry", rd[4], 0);
    chk("R10 counter cleared", tap, 0);
    tick(7);
    chk("R10 flag not yet", rd[4], 0);
    tick(1);
    chk("R10 flag after restart", rd[4], 1);
  endtask

  task automatic t_irq();
    clean(2'd0, 1'b1);
    chk("R9 irq low with flag 0", irq, 0);
    tick(8);
    chk("R9 irq high", irq, 1);
    wr(cfg(2'd0, 1'b0, 1'b1, 1'b1));
    chk("R9 irq masked", irq, 0);
    chk("R9 flag kept when masked", rd[4], 1);
    wr(cfg(2'd0, 1'b1, 1'b1, 1'b1));
    chk("R9 irq unmasked", irq, 1);
  endtask

  task automatic t_mid_reset();
    tick(5);
    rst = 1'b1;
    tick(2);
    rst = 1'b0;
    chk("R1 rdata after mid reset", rd, 8'h08);
    chk("R1 tap after mid reset", tap, 0);
    chk("R1 irq after mid reset", irq, 0);
  endtask

  initial begin
    t_reset();
    t_count();
    t_init();
    t_events();
    t_sel();
    t_flag();
    t_clear_at_carry();
    t_irq();
    t_mid_reset();
    tick(2);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule